// File: doc/BRIEF.md
# Acknowledge-Polling I2C Memory Sequencer

This block is an I2C bus master that runs one memory operation per command against a serial memory that may still be busy with an internal write. It does not wait out a fixed worst-case write time. It probes the slave with a START followed by the write-mode select byte. A missing acknowledge means "still busy", so the probe is repeated with a repeated START. Once the slave acknowledges, the select byte already on the bus becomes the first byte of the real operation.

After the acknowledge the sequencer does one of three things:
- For a write, it sends a two-byte address and one data byte, then a STOP.
- For a random read, it sends the address, issues a repeated START, sends the read-mode select, takes one byte without acknowledging it, then issues a STOP.
- For a non-memory ("ping") command, it issues a STOP right after the acknowledged select byte.

If the slave never answers within a parameterised number of probes, the bus is released with a STOP and a timeout pulse is raised. SCL and SDA are driven as open-drain pull-down enables. Clock stretching and arbitration are not handled.

Top module: `i2c_ackpoll_seq`

## Requirements
- R1: After reset and whenever `cmd_ready` is high, both `scl_oe` and `sda_oe` are 0 (bus released; an enable of 1 pulls the line low). Every operation begins with a START followed by the select byte {DEV_ADDR, 0}.
- R2: When that select byte is not acknowledged, the sequencer issues a repeated START and sends {DEV_ADDR, 0} again. It keeps doing so until the slave acknowledges. A slave that is busy for k probes therefore sees k+1 write-mode select bytes.
- R3: For `cmd_op` 0 (write) and 1 (read), the byte that follows the acknowledged select is the address high byte {3'b000, addr[12:8]}. The address low byte addr[7:0] comes next.
- R4: For a write, the data byte `cmd_wdata` follows the address low byte. Then comes a STOP, and `done` pulses for one cycle.
- R5: For a read, a repeated START follows the address, then {DEV_ADDR, 1}, then one byte is received and not acknowledged, then a STOP. `done` and `rd_valid` pulse together, with that byte on `rd_data`.
- R6: For `cmd_op` 2 (and the unused code 3), a STOP follows the acknowledged select byte directly, no address or data byte is sent, and `done` pulses.
- R7: After POLL_LIMIT consecutive unacknowledged select bytes, the sequencer issues a STOP and pulses `tmo_err` instead of `done`. The bus is then released.
- R8: SDA changes while SCL is high only to form START, repeated START or STOP. Within a byte, SCL rising edges are CLK_DIV system clocks apart. CLK_DIV must be a multiple of 4, at least 4.
- R9: `cmd_ready` is high only while idle. A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_valid` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted this cycle if valid |
| cmd_op | input | 2 | 0 write, 1 random read, 2 or 3 ping |
| cmd_addr | input | 13 | Memory byte address |
| cmd_wdata | input | 8 | Byte to write |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle pulse on successful completion |
| rd_valid | output | 1 | One-cycle pulse with `done` for a read |
| rd_data | output | 8 | Byte returned by a read |
| tmo_err | output | 1 | One-cycle pulse when polling gave up |

## Verification
The bench runs a model slave that stays busy for a configurable number of probes. It sweeps all three command kinds against busy counts 0 to 3 and against addresses at both ends and in the middle of the 13-bit range. Varying the busy count separates correct retry behaviour from a sequencer that gives up or skips the probe. Varying the command kind shows whether the branch after the acknowledge is taken correctly. The extreme addresses show whether the high byte is masked and ordered. A slave busy beyond the poll limit exercises the timeout path, and a command offered mid-transfer shows whether the handshake ignores it.

// File: rtl/apoll_pkg.sv
package apoll_pkg;
  localparam int ADDR_W = 13;

  typedef enum logic [1:0] {
    CMD_WRITE = 2'd0,
    CMD_READ  = 2'd1,
    CMD_PING  = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    PR_START,
    PR_RSTART,
    PR_STOP,
    PR_WBYTE,
    PR_RBYTE
  } prim_e;

  function automatic logic [7:0] sel_byte(input logic [6:0] dev, input logic rd);
    return {dev, rd};
  endfunction

  function automatic logic [7:0] addr_hi_byte(input logic [ADDR_W-1:0] a);
    return {{(16-ADDR_W){1'b0}}, a[ADDR_W-1:8]};
  endfunction

  function automatic logic [7:0] addr_lo_byte(input logic [ADDR_W-1:0] a);
    return a[7:0];
  endfunction
endpackage

// File: rtl/apoll_bit_engine.sv
module apoll_bit_engine
  import apoll_pkg::*;
#(
  parameter int QTR = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  prim_e      op,
  input  logic [7:0] op_byte,
  input  logic       sda_in,
  output logic       done,
  output logic       ack_seen,
  output logic [7:0] rd_byte,
  output logic       scl_lo,
  output logic       sda_lo
);
  localparam int TW = (QTR > 1) ? $clog2(QTR) : 1;

  logic [TW-1:0] tcnt;
  logic          busy_q;
  prim_e         op_q;
  logic [7:0]    shreg;
  logic [3:0]    bitn;
  logic [1:0]    q;
  logic          cond_q;
  logic          pat_scl, pat_sda, pat_cond;

  wire qtr_end   = (tcnt == TW'(QTR - 1));
  wire is_byte   = (op_q == PR_WBYTE) || (op_q == PR_RBYTE);
  wire last_slot = is_byte ? (bitn == 4'd8) : 1'b1;
  wire sample_pt = busy_q && qtr_end && (q == 2'd2);
  wire slot_end  = busy_q && qtr_end && (q == 2'd3);

  // quarter-by-quarter line pattern; outputs are its registered copy
  always_comb begin
    pat_cond = 1'b0;
    case (op_q)
      PR_START:  begin pat_scl = (q == 2'd3); pat_sda = (q != 2'd0); pat_cond = 1'b1; end
      PR_RSTART: begin pat_scl = (q == 2'd0) || (q == 2'd3); pat_sda = (q >= 2'd2); pat_cond = 1'b1; end
      PR_STOP:   begin pat_scl = (q == 2'd0); pat_sda = (q <= 2'd1); pat_cond = 1'b1; end
      default:   begin
        pat_scl = (q == 2'd0) || (q == 2'd3);
        pat_sda = (op_q == PR_WBYTE) && (bitn < 4'd8) && !shreg[7];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; op_q <= PR_STOP; shreg <= 8'h00; bitn <= 4'd0; q <= 2'd0;
      tcnt <= '0; scl_lo <= 1'b0; sda_lo <= 1'b0; cond_q <= 1'b0;
      done <= 1'b0; ack_seen <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy_q) begin
        if (op_valid) begin
          busy_q <= 1'b1; op_q <= op; shreg <= op_byte;
          bitn <= 4'd0; q <= 2'd0; tcnt <= '0;
        end
      end else begin
        scl_lo <= pat_scl;
        sda_lo <= pat_sda;
        cond_q <= pat_cond;
        if (qtr_end) tcnt <= '0;
        else         tcnt <= tcnt + 1'b1;
        if (sample_pt) begin
          if (op_q == PR_RBYTE && bitn < 4'd8) shreg <= {shreg[6:0], sda_in};
          if (op_q == PR_WBYTE && bitn == 4'd8) ack_seen <= !sda_in;
        end
        if (slot_end) begin
          if (last_slot) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            q    <= 2'd0;
            if (op_q == PR_WBYTE) shreg <= {shreg[6:0], 1'b0};
          end
        end else if (busy_q && qtr_end) begin
          q <= q + 1'b1;
        end
      end
    end
  end

  assign rd_byte = shreg;

  AST_SDA_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_lo && $past(!scl_lo) && (sda_lo != $past(sda_lo))) |-> cond_q); // R8
  AST_ISSUE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !busy_q); // R1
endmodule

// File: rtl/apoll_ctrl.sv
module apoll_ctrl
  import apoll_pkg::*;
#(
  parameter int         POLL_LIMIT = 1000,
  parameter logic [6:0] DEV_ADDR   = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              op_valid,
  output prim_e             op,
  output logic [7:0]        op_byte,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [7:0]        eng_rbyte,
  output logic              done,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              tmo_err
);
  localparam int CW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_SELW, S_RSTRT_POLL, S_AHI, S_ALO,
    S_DATA, S_RSTRT_RD, S_SELR, S_READ, S_STOP
  } st_e;

  st_e               st;
  logic              issued;
  cmd_e              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [CW-1:0]     fails;
  logic              tmo_q;

  wire limit_hit  = (fails == CW'(POLL_LIMIT - 1));
  wire mem_op     = (op_q == CMD_WRITE) || (op_q == CMD_READ);
  wire poll_nack  = eng_done && (st == S_SELW) && !eng_ack;

  assign cmd_ready = (st == S_IDLE);
  assign op_valid  = (st != S_IDLE) && !issued;

  always_comb begin
    op = PR_WBYTE;
    op_byte = 8'h00;
    case (st)
      S_START:                 op = PR_START;
      S_RSTRT_POLL, S_RSTRT_RD: op = PR_RSTART;
      S_SELW:                  op_byte = sel_byte(DEV_ADDR, 1'b0);
      S_SELR:                  op_byte = sel_byte(DEV_ADDR, 1'b1);
      S_AHI:                   op_byte = addr_hi_byte(addr_q);
      S_ALO:                   op_byte = addr_lo_byte(addr_q);
      S_DATA:                  op_byte = wdata_q;
      S_READ:                  op = PR_RBYTE;
      default:                 op = PR_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; issued <= 1'b0; op_q <= CMD_WRITE; addr_q <= '0; wdata_q <= 8'h00;
      fails <= '0; tmo_q <= 1'b0; done <= 1'b0; rd_valid <= 1'b0; rd_data <= 8'h00;
      tmo_err <= 1'b0;
    end else begin
      done <= 1'b0; rd_valid <= 1'b0; tmo_err <= 1'b0;
      if (op_valid) issued <= 1'b1;
      if (st == S_IDLE) begin
        if (cmd_valid) begin
          op_q <= cmd_e'(cmd_op); addr_q <= cmd_addr; wdata_q <= cmd_wdata;
          fails <= '0; tmo_q <= 1'b0; st <= S_START;
        end
      end else if (eng_done) begin
        issued <= 1'b0;
        case (st)
          S_START:      st <= S_SELW;
          S_SELW: begin
            if (eng_ack)        st <= mem_op ? S_AHI : S_STOP;
            else if (limit_hit) begin tmo_q <= 1'b1; st <= S_STOP; end
            else begin fails <= fails + 1'b1; st <= S_RSTRT_POLL; end
          end
          S_RSTRT_POLL: st <= S_SELW;
          S_AHI:        st <= S_ALO;
          S_ALO:        st <= (op_q == CMD_WRITE) ? S_DATA : S_RSTRT_RD;
          S_DATA:       st <= S_STOP;
          S_RSTRT_RD:   st <= S_SELR;
          S_SELR:       st <= S_READ;
          S_READ: begin rd_data <= eng_rbyte; st <= S_STOP; end
          default: begin
            st <= S_IDLE;
            if (tmo_q) tmo_err <= 1'b1;
            else begin done <= 1'b1; rd_valid <= (op_q == CMD_READ); end
          end
        endcase
      end
    end
  end

  AST_DONE_TMO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && tmo_err)); // R7
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_nack |-> (fails < CW'(POLL_LIMIT))); // R7
  AST_RDV_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R9
endmodule

// File: rtl/i2c_ackpoll_seq.sv
module i2c_ackpoll_seq
  import apoll_pkg::*;
#(
  parameter int         CLK_DIV    = 8,
  parameter int         POLL_LIMIT = 1000,
  parameter logic [6:0] DEV_ADDR   = 7'h50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [12:0] cmd_addr,
  input  logic [7:0]  cmd_wdata,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        done,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        tmo_err
);
  localparam int QTR = CLK_DIV / 4;

  logic       op_valid, eng_done, eng_ack;
  prim_e      op;
  logic [7:0] op_byte, eng_rbyte;

  apoll_ctrl #(.POLL_LIMIT(POLL_LIMIT), .DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .op_valid(op_valid), .op(op), .op_byte(op_byte),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_rbyte(eng_rbyte),
    .done(done), .rd_valid(rd_valid), .rd_data(rd_data), .tmo_err(tmo_err)
  );

  apoll_bit_engine #(.QTR(QTR)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op(op), .op_byte(op_byte), .sda_in(sda_in),
    .done(eng_done), .ack_seen(eng_ack), .rd_byte(eng_rbyte),
    .scl_lo(scl_oe), .sda_lo(sda_oe)
  );

  AST_BUS_FREE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!scl_oe && !sda_oe)); // R1
endmodule

// File: tb/i2c_ackpoll_seq_tb.sv
module i2c_ackpoll_seq_tb_top;
  localparam int         CLK_DIV    = 8;
  localparam int         POLL_LIMIT = 6;
  localparam logic [6:0] DEV        = 7'h50;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [12:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = 8'h00;
  logic        cmd_ready, scl_oe, sda_oe, done, rd_valid, tmo_err;
  logic [7:0]  rd_data;
  logic        s_lo = 1'b0;

  wire scl_bus = !scl_oe;
  wire sda_bus = !(sda_oe | s_lo);

  i2c_ackpoll_seq #(.CLK_DIV(CLK_DIV), .POLL_LIMIT(POLL_LIMIT), .DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .rd_valid(rd_valid),
    .rd_data(rd_data), .tmo_err(tmo_err)
  );

  int total = 0, bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_val(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction

  // ---------------- slave model (sole owner of its state) ----------------
  int clr_tok = 0, seen_tok = 0, busy_cfg = 0;
  int busy_left = 0, starts = 0, stops = 0, sel_w = 0, sel_r = 0, post_sel = 0, data_cnt = 0;
  int cyc = 0, last_rise = 0, min_per = 0, max_per = 0;
  logic [7:0] ahi = 0, alo = 0, drx = 0, sh = 0, txb = 0;
  logic pscl = 1, psda = 1, active = 0, armed = 0, tx = 0, tx_pend = 0, acked = 0, mack = 0;
  int bitcnt = 0, bidx = 0;

  always @(negedge clk) begin
    cyc++;
    if (clr_tok != seen_tok) begin
      seen_tok = clr_tok; busy_left = busy_cfg; starts = 0; stops = 0; sel_w = 0; sel_r = 0;
      post_sel = 0; data_cnt = 0; min_per = 1000; max_per = 0; mack = 1'b1;
    end
    if (pscl && scl_bus && psda && !sda_bus) begin
      starts++; active = 1; armed = 0; bitcnt = 0; bidx = 0; tx = 0; tx_pend = 0; s_lo = 0;
    end else if (pscl && scl_bus && !psda && sda_bus) begin
      stops++; active = 0; s_lo = 0;
    end else if (active) begin
      if (!pscl && scl_bus) begin
        armed = 1;
        if (bitcnt >= 1) begin
          if (cyc - last_rise < min_per) min_per = cyc - last_rise;
          if (cyc - last_rise > max_per) max_per = cyc - last_rise;
        end
        last_rise = cyc;
        if (!tx && bitcnt < 8) sh = {sh[6:0], sda_bus};
        if (tx && bitcnt == 8) mack = !sda_bus;
      end else if (pscl && !scl_bus && armed) begin
        if (bitcnt < 8) begin
          bitcnt++;
          if (bitcnt == 8) begin
            if (tx) s_lo = 0;
            else begin
              acked = 1;
              if (bidx == 0) begin
                if (sh == {DEV, 1'b0}) begin
                  sel_w++;
                  if (busy_left > 0) begin busy_left--; acked = 0; end
                end else if (sh == {DEV, 1'b1}) begin
                  sel_r++; tx_pend = 1; txb = mem_val({ahi[4:0], alo});
                end else acked = 0;
              end else begin
                post_sel++;
                if (bidx == 1) ahi = sh;
                else if (bidx == 2) alo = sh;
                else begin drx = sh; data_cnt++; end
              end
              bidx++;
              s_lo = acked;
            end
          end else if (tx) s_lo = !txb[7 - bitcnt];
        end else begin
          bitcnt = 0; s_lo = 0;
          if (tx_pend) begin tx = 1; tx_pend = 0; s_lo = !txb[7]; end
          else if (tx || !acked) active = 0;
        end
      end
    end
    pscl = scl_bus; psda = sda_bus;
  end

  // ---------------- stimulus ----------------
  logic got_done, got_rdv, got_tmo;
  logic [7:0] got_rd;

  task automatic run_txn(input int op, input logic [12:0] a, input logic [7:0] wd,
                         input int busy, input bit inject);
    int n;
    @(posedge clk); busy_cfg = busy; clr_tok++;
    @(negedge clk);
    chk("R9 ready before", int'(cmd_ready), 1);
    cmd_valid = 1; cmd_op = 2'(op); cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    chk("R9 ready drops", int'(cmd_ready), 0);
    n = 0;
    got_done = 0; got_rdv = 0; got_tmo = 0; got_rd = 0;
    while (!(done || tmo_err) && n < 20000) begin
      @(negedge clk); n++;
      if (inject && n == 30) begin
        cmd_valid = 1; cmd_op = 2'd1; cmd_addr = 13'h0123;
      end else cmd_valid = 0;
    end
    cmd_valid = 0;
    if (n >= 20000) chk("R1 txn watchdog", 0, 1);
    got_done = done; got_rdv = rd_valid; got_tmo = tmo_err; got_rd = rd_data;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset scl", int'(scl_oe), 0);
    chk("R1 reset sda", int'(sda_oe), 0);
    chk("R9 reset ready", int'(cmd_ready), 1);
    chk("R4 reset done", int'(done), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int op = 0; op < 3; op++)
      for (int busy = 0; busy < 4; busy++)
        for (int ai = 0; ai < 3; ai++) begin
          logic [12:0] a;
          logic [7:0] wd;
          a  = (ai == 0) ? 13'h0000 : (ai == 1) ? 13'h1FFF : 13'((busy * 1237 + op * 611 + 77) & 13'h1FFF);
          wd = 8'((op * 53 + busy * 29 + ai * 101) & 8'hFF);
          run_txn(op, a, wd, busy, (op == 0 && busy == 1 && ai == 2));
          chk("R2 select count", sel_w, busy + 1);
          chk("R7 no timeout", int'(got_tmo), 0);
          chk("R4 done pulse", int'(got_done), 1);
          chk("R1 one stop", stops, 1);
          chk("R1 released", int'(scl_oe | sda_oe), 0);
          chk("R8 period min", min_per, CLK_DIV);
          chk("R8 period max", max_per, CLK_DIV);
          if (op == 0) begin
            chk("R2 starts", starts, busy + 1);
            chk("R3 addr hi", int'(ahi), int'({3'b000, a[12:8]}));
            chk("R3 addr lo", int'(alo), int'(a[7:0]));
            chk("R4 data", int'(drx), int'(wd));
            chk("R4 data count", data_cnt, 1);
            chk("R4 no rd_valid", int'(got_rdv), 0);
          end else if (op == 1) begin
            chk("R5 starts", starts, busy + 2);
            chk("R3 addr hi rd", int'(ahi), int'({3'b000, a[12:8]}));
            chk("R3 addr lo rd", int'(alo), int'(a[7:0]));
            chk("R5 read select", sel_r, 1);
            chk("R5 master nack", int'(mack), 0);
            chk("R5 rd_valid", int'(got_rdv), 1);
            chk("R5 rd_data", int'(got_rd), int'(mem_val(a)));
            chk("R5 no data written", data_cnt, 0);
          end else begin
            chk("R6 starts", starts, busy + 1);
            chk("R6 no bytes after select", post_sel, 0);
            chk("R6 no read select", sel_r, 0);
          end
        end

    // never-ready slave: timeout then recovery
    run_txn(0, 13'h0456, 8'hC3, 100, 0);
    chk("R7 tmo pulse", int'(got_tmo), 1);
    chk("R7 no done", int'(got_done), 0);
    chk("R7 attempts", sel_w, POLL_LIMIT);
    chk("R7 stop issued", stops, 1);
    chk("R7 nothing written", data_cnt, 0);
    chk("R7 bus released", int'(scl_oe | sda_oe), 0);
    chk("R7 ready again", int'(cmd_ready), 1);
    run_txn(2, 13'h0000, 8'h00, POLL_LIMIT - 1, 0);
    chk("R7 limit-1 busy succeeds", int'(got_done), 1);
    chk("R7 limit-1 attempts", sel_w, POLL_LIMIT);

    // the command offered mid-transfer must not have been queued
    repeat (300) @(negedge clk);
    chk("R9 no stray transfer", starts, POLL_LIMIT);
    chk("R9 idle bus", int'(scl_oe | sda_oe), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule